// File: doc/BRIEF.md
# Unsupported-Instruction Halt Detector

This block sits beside the decode stage of a small RV32IM core that has no exception machinery yet. Each fetched 32-bit instruction word is sorted into one of three classes. It is either supported, a deliberate no-op, or unsupported. A fetched word is only examined while its fetch-valid strobe is high. When an unsupported word is seen, the block stops the core at once. It also raises a sticky flag that a testbench can watch, and it records the program counter and the raw instruction word of the offender.

The aim is to make unimplemented operations fail loudly instead of passing through as hidden no-ops. The environment call, the breakpoint, the instruction-stream fence and every CSR access all stop the core. So does any encoding outside the base integer set and the multiply/divide set. The memory-ordering fence is the single instruction that is accepted and then ignored. Along with the captured diagnostics, the block holds a cause code in the numbering a later trap unit would use, so the value is ready when exceptions are added.

Top module: `illegal_halt_detector`

## Requirements
- R1: After reset, `halt_o` and `illegal_instr_o` are 0 and `bad_pc_o`, `bad_insn_o` and `cause_o` are all zero.
- R2: Every legal base-integer encoding is accepted and never causes a halt. The legal encodings are: LUI, AUIPC and JAL; JALR with funct3 000; branches with funct3 other than 010 and 011; loads with funct3 000, 001, 010, 100 or 101; stores with funct3 000 to 010; OP-IMM, where shifts need funct7 0000000 (or 0100000 for a right shift); and OP with funct7 0000000, or 0100000 together with funct3 000 or 101.
- R3: When `M_EXT`=1 (the default), the OP opcode 0110011 with funct7 0000001 is legal for all eight funct3 values.
- R4: Each of these words halts with cause 2: a word whose bits [1:0] are not 11, an unassigned opcode, a reserved funct3 value, or a reserved funct7 value such as a left shift-immediate with funct7 0100000.
- R5: The memory-ordering fence (opcode 0001111, funct3 000) is a no-op and does not halt.
- R6: The instruction-stream fence (opcode 0001111, funct3 001) halts with cause 2. So does any word with the SYSTEM opcode 1110011 other than the two exact words in R7, which covers every CSR access and the return and wait forms.
- R7: The word 0x00000073 (environment call) halts with cause 11. The word 0x00100073 (breakpoint) halts with cause 3.
- R8: `halt_o` rises in the same cycle as a valid unsupported word. From the next clock edge, `illegal_instr_o` is 1 and the captured PC, word and cause appear on their outputs.
- R9: Halt, flag and captured values are sticky until reset. Only the first offending instruction is recorded, and later fetches change none of the outputs.
- R10: While `insn_valid_i` is 0, no word causes a halt or changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid_i | input | 1 | Fetched word is valid this cycle |
| insn_i | input | 32 | Fetched instruction word |
| pc_i | input | PC_W | Address of the fetched word |
| halt_o | output | 1 | Stop the core (same cycle, then held) |
| illegal_instr_o | output | 1 | Sticky flag for the testbench |
| bad_pc_o | output | PC_W | PC of the first unsupported word |
| bad_insn_o | output | 32 | First unsupported word |
| cause_o | output | CAUSE_W | 2 unsupported, 3 breakpoint, 11 environment call |

## Verification
A wrong decode entry shows up on `halt_o` in the same cycle the word is presented. A legal word that is wrongly rejected raises a halt that should not be there. An unsupported word that is wrongly accepted leaves `halt_o` low when it should be high. A capture register that is corrupted or reloaded shows up one edge after the offending fetch, as a wrong PC, word or cause. It also shows up later, when a second bad fetch alters values that must stay frozen. A sticky bit that is lost shows up as `illegal_instr_o` dropping on the cycle after it was set.

// File: rtl/ihd_pkg.sv
package ihd_pkg;

   typedef enum logic [1:0] {
      INSN_OK  = 2'd0,
      INSN_NOP = 2'd1,
      INSN_BAD = 2'd2
   } insn_class_t;

   // major opcodes (bits [6:0])
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_FENCES = 7'b0001111;
   localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

   localparam logic [6:0] F7_BASE = 7'b0000000;
   localparam logic [6:0] F7_ALT  = 7'b0100000;
   localparam logic [6:0] F7_MULD = 7'b0000001;

   localparam logic [31:0] WORD_ECALL  = 32'h0000_0073;
   localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

   localparam int CAUSE_UNSUPPORTED = 2;
   localparam int CAUSE_BREAKPOINT  = 3;
   localparam int CAUSE_ENVCALL_M   = 11;

endpackage

// File: rtl/ihd_classify.sv
module ihd_classify
   import ihd_pkg::*;
#(
   parameter bit M_EXT   = 1'b1,
   parameter int CAUSE_W = 4
) (
   input  logic [31:0]        insn_i,
   output insn_class_t        cls_o,
   output logic [CAUSE_W-1:0] cause_o
);

   localparam logic [CAUSE_W-1:0] C_BAD = CAUSE_W'(CAUSE_UNSUPPORTED);
   localparam logic [CAUSE_W-1:0] C_BRK = CAUSE_W'(CAUSE_BREAKPOINT);
   localparam logic [CAUSE_W-1:0] C_ENV = CAUSE_W'(CAUSE_ENVCALL_M);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;
   logic       muldiv_ok;

   assign opc = insn_i[6:0];
   assign f3  = insn_i[14:12];
   assign f7  = insn_i[31:25];

   generate
      if (M_EXT) begin : g_muldiv
         assign muldiv_ok = (f7 == F7_MULD);
      end else begin : g_no_muldiv
         assign muldiv_ok = 1'b0;
      end
   endgenerate

   // per-opcode legality of the funct3/funct7 fields
   logic ok_branch, ok_load, ok_store, ok_opimm, ok_op;

   always_comb begin
      ok_branch = (f3 != 3'b010) && (f3 != 3'b011);
      ok_load   = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010) ||
                  (f3 == 3'b100) || (f3 == 3'b101);
      ok_store  = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010);
      unique case (f3)
         3'b001:  ok_opimm = (f7 == F7_BASE);
         3'b101:  ok_opimm = (f7 == F7_BASE) || (f7 == F7_ALT);
         default: ok_opimm = 1'b1;
      endcase
      ok_op = (f7 == F7_BASE) ||
              ((f7 == F7_ALT) && ((f3 == 3'b000) || (f3 == 3'b101))) ||
              muldiv_ok;
   end

   always_comb begin
      cls_o   = INSN_BAD;
      cause_o = C_BAD;
      if (insn_i[1:0] == 2'b11) begin
         unique case (opc)
            OPC_LUI, OPC_AUIPC, OPC_JAL: cls_o = INSN_OK;
            OPC_JALR:   if (f3 == 3'b000) cls_o = INSN_OK;
            OPC_BRANCH: if (ok_branch)    cls_o = INSN_OK;
            OPC_LOAD:   if (ok_load)      cls_o = INSN_OK;
            OPC_STORE:  if (ok_store)     cls_o = INSN_OK;
            OPC_OPIMM:  if (ok_opimm)     cls_o = INSN_OK;
            OPC_OP:     if (ok_op)        cls_o = INSN_OK;
            OPC_FENCES: if (f3 == 3'b000) cls_o = INSN_NOP;
            OPC_SYSTEM: begin
               if (insn_i == WORD_ECALL)       cause_o = C_ENV;
               else if (insn_i == WORD_EBREAK) cause_o = C_BRK;
            end
            default: ;
         endcase
      end
      if (cls_o != INSN_BAD) cause_o = '0;
   end

endmodule

// File: rtl/ihd_capture.sv
module ihd_capture #(
   parameter int PC_W    = 32,
   parameter int CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [31:0]        insn_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic               halted_o,
   output logic [PC_W-1:0]    pc_o,
   output logic [31:0]        insn_o,
   output logic [CAUSE_W-1:0] cause_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_o <= 1'b0;
         pc_o     <= '0;
         insn_o   <= '0;
         cause_o  <= '0;
      end else if (fire_i && !halted_o) begin
         halted_o <= 1'b1;
         pc_o     <= pc_i;
         insn_o   <= insn_i;
         cause_o  <= cause_i;
      end
   end

endmodule

// File: rtl/illegal_halt_detector.sv
module illegal_halt_detector
   import ihd_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter bit M_EXT   = 1'b1,
   parameter int CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_valid_i,
   input  logic [31:0]        insn_i,
   input  logic [PC_W-1:0]    pc_i,
   output logic               halt_o,
   output logic               illegal_instr_o,
   output logic [PC_W-1:0]    bad_pc_o,
   output logic [31:0]        bad_insn_o,
   output logic [CAUSE_W-1:0] cause_o
);

   generate
      if (PC_W < 2 || PC_W > 64) begin : g_bad_pcw
         $error("PC_W must lie in 2..64");
      end
      if (CAUSE_W < 4) begin : g_bad_causew
         $error("CAUSE_W must hold the value 11");
      end
   endgenerate

   insn_class_t        cls;
   logic [CAUSE_W-1:0] cause_now;
   logic               bad_now;
   logic               halted_q;

   ihd_classify #(.M_EXT(M_EXT), .CAUSE_W(CAUSE_W)) i_classify (
      .insn_i  (insn_i),
      .cls_o   (cls),
      .cause_o (cause_now)
   );

   assign bad_now = insn_valid_i && (cls == INSN_BAD);

   ihd_capture #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (bad_now),
      .pc_i     (pc_i),
      .insn_i   (insn_i),
      .cause_i  (cause_now),
      .halted_o (halted_q),
      .pc_o     (bad_pc_o),
      .insn_o   (bad_insn_o),
      .cause_o  (cause_o)
   );

   assign halt_o          = halted_q || bad_now;
   assign illegal_instr_o = halted_q;

endmodule

// File: rtl/ihd_checker.sv
module ihd_checker #(
   parameter int PC_W    = 32,
   parameter int CAUSE_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               insn_valid_i,
   input logic [31:0]        insn_i,
   input logic [PC_W-1:0]    pc_i,
   input logic               halt_o,
   input logic               illegal_instr_o,
   input logic [PC_W-1:0]    bad_pc_o,
   input logic [31:0]        bad_insn_o,
   input logic [CAUSE_W-1:0] cause_o
);

   // R1: nothing captured while the flag is clear
   a_r1_clear_until_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !illegal_instr_o |-> (bad_pc_o == '0 && bad_insn_o == '0 && cause_o == '0));

   // R8: a valid fetch that halts before the flag is set is captured at the next edge
   a_r8_capture_next: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid_i && halt_o && !illegal_instr_o) |=>
      (illegal_instr_o && bad_pc_o == $past(pc_i) && bad_insn_o == $past(insn_i)));

   // R9: flag never drops
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_instr_o |=> illegal_instr_o);

   // R9: captured values frozen once set
   a_r9_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_instr_o |=> ($stable(bad_pc_o) && $stable(bad_insn_o) && $stable(cause_o)));

   // R9: halt held while the flag is set
   a_r9_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_instr_o |-> halt_o);

   // R10: bubbles do not halt
   a_r10_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!insn_valid_i && !illegal_instr_o) |-> !halt_o);

   // R7: only the three defined cause codes are ever captured
   a_r7_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_instr_o |-> (cause_o == CAUSE_W'(2) || cause_o == CAUSE_W'(3) ||
                           cause_o == CAUSE_W'(11)));

endmodule

bind illegal_halt_detector ihd_checker #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) i_ihd_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .insn_valid_i    (insn_valid_i),
   .insn_i          (insn_i),
   .pc_i            (pc_i),
   .halt_o          (halt_o),
   .illegal_instr_o (illegal_instr_o),
   .bad_pc_o        (bad_pc_o),
   .bad_insn_o      (bad_insn_o),
   .cause_o         (cause_o)
);

// File: tb/test_illegal_halt_detector.sv
`timescale 1ns/1ps
module test_illegal_halt_detector;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid_i = 1'b0;
   logic [31:0] insn_i = '0;
   logic [31:0] pc_i = '0;
   logic        halt_o, illegal_instr_o;
   logic [31:0] bad_pc_o, bad_insn_o;
   logic [3:0]  cause_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   illegal_halt_detector #(.PC_W(32), .M_EXT(1'b1), .CAUSE_W(4)) i_illegal_halt_detector (
      .clk(clk), .rst_n(rst_n), .insn_valid_i(insn_valid_i), .insn_i(insn_i),
      .pc_i(pc_i), .halt_o(halt_o), .illegal_instr_o(illegal_instr_o),
      .bad_pc_o(bad_pc_o), .bad_insn_o(bad_insn_o), .cause_o(cause_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      insn_valid_i = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // present one word at a negedge, check halt in that cycle, drop valid after the edge
   task automatic present(input logic [31:0] w, input logic [31:0] pc, input bit exp_halt,
                          input string tag);
      @(negedge clk);
      insn_i = w; pc_i = pc; insn_valid_i = 1'b1;
      #1;
      chk(tag, {31'd0, halt_o}, {31'd0, exp_halt});
      @(negedge clk);
      insn_valid_i = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 halt", {31'd0, halt_o}, 32'd0);
      chk("R1 flag", {31'd0, illegal_instr_o}, 32'd0);
      chk("R1 pc", bad_pc_o, 32'd0);
      chk("R1 insn", bad_insn_o, 32'd0);
      chk("R1 cause", {28'd0, cause_o}, 32'd0);
   endtask

   task automatic t_legal_base();
      logic [31:0] words [14] = '{32'h123450B7, 32'h00001097, 32'h0000006F, 32'h00008067,
                                  32'h00000063, 32'h00017063, 32'h00012083, 32'h00015083,
                                  32'h00112023, 32'h00100093, 32'h4030D093, 32'h00309093,
                                  32'h402081B3, 32'h4020D1B3};
      do_reset();
      for (int i = 0; i < 14; i++) present(words[i], 32'h100 + 4*i, 1'b0, "R2 legal base");
      chk("R2 flag stays clear", {31'd0, illegal_instr_o}, 32'd0);
   endtask

   task automatic t_muldiv();
      do_reset();
      for (int f = 0; f < 8; f++)
         present(32'h022081B3 | (f << 12), 32'h200 + 4*f, 1'b0, "R3 muldiv legal");
      chk("R3 flag clear", {31'd0, illegal_instr_o}, 32'd0);
   endtask

   task automatic t_fence_nop();
      do_reset();
      present(32'h0FF0000F, 32'h300, 1'b0, "R5 fence no halt");
      present(32'h0000000F, 32'h304, 1'b0, "R5 fence no halt");
      chk("R5 flag clear", {31'd0, illegal_instr_o}, 32'd0);
      chk("R5 pc untouched", bad_pc_o, 32'd0);
   endtask

   task automatic t_bubble();
      do_reset();
      @(negedge clk);
      insn_i = 32'h00100073; pc_i = 32'h400; insn_valid_i = 1'b0;
      #1;
      chk("R10 no halt on bubble", {31'd0, halt_o}, 32'd0);
      @(negedge clk);
      chk("R10 flag clear", {31'd0, illegal_instr_o}, 32'd0);
      chk("R10 pc untouched", bad_pc_o, 32'd0);
      chk("R10 cause untouched", {28'd0, cause_o}, 32'd0);
   endtask

   // bad word: halt same cycle with flag still low, capture after the edge
   task automatic t_bad(input logic [31:0] w, input logic [31:0] pc, input int exp_cause,
                        input string tag);
      do_reset();
      @(negedge clk);
      insn_i = w; pc_i = pc; insn_valid_i = 1'b1;
      #1;
      chk({tag, " R8 halt same cycle"}, {31'd0, halt_o}, 32'd1);
      chk({tag, " R8 flag not yet"}, {31'd0, illegal_instr_o}, 32'd0);
      @(negedge clk);
      insn_valid_i = 1'b0;
      chk({tag, " R8 flag"}, {31'd0, illegal_instr_o}, 32'd1);
      chk({tag, " pc"}, bad_pc_o, pc);
      chk({tag, " insn"}, bad_insn_o, w);
      chk({tag, " cause"}, {28'd0, cause_o}, exp_cause);
   endtask

   task automatic t_sticky();
      do_reset();
      present(32'h00100093, 32'h500, 1'b0, "R9 legal before");
      present(32'h0000100F, 32'h504, 1'b1, "R9 first bad");
      present(32'h00000073, 32'h508, 1'b1, "R9 second bad");
      present(32'h00100093, 32'h50C, 1'b1, "R9 legal after still halted");
      repeat (3) @(negedge clk);
      chk("R9 flag held", {31'd0, illegal_instr_o}, 32'd1);
      chk("R9 first pc kept", bad_pc_o, 32'h504);
      chk("R9 first insn kept", bad_insn_o, 32'h0000100F);
      chk("R9 first cause kept", {28'd0, cause_o}, 32'd2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_legal_base();
      t_muldiv();
      t_fence_nop();
      t_bubble();
      t_bad(32'h00000073, 32'h0000_0600, 11, "R7 ecall");
      t_bad(32'h00100073, 32'h0000_0604, 3, "R7 ebreak");
      t_bad(32'h0000100F, 32'h0000_0608, 2, "R6 fence.i");
      t_bad(32'h300110F3, 32'h0000_060C, 2, "R6 csr write");
      t_bad(32'h30200073, 32'h0000_0610, 2, "R6 mret");
      t_bad(32'h10500073, 32'h0000_0614, 2, "R6 wfi");
      t_bad(32'h0000007F, 32'h0000_0618, 2, "R4 unknown opcode");
      t_bad(32'h40309093, 32'h0000_061C, 2, "R4 slli funct7");
      t_bad(32'h402091B3, 32'h0000_0620, 2, "R4 op funct7 alt sll");
      t_bad(32'h00013083, 32'h0000_0624, 2, "R4 load funct3 011");
      t_bad(32'h00000001, 32'h0000_0628, 2, "R4 compressed low bits");
      t_bad(32'h0400D093, 32'h0000_062C, 2, "R4 srli funct7");
      t_sticky();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule